// File: doc/BRIEF.md
# Mains-Paced Four-Digit Ring-Counter Clock

This block keeps hours and minutes in 24-hour form from a mains tick of 50 Hz that has already been conditioned. The tick passes through a two-flop synchronizer and a rising-edge detector. Each mains cycle therefore yields one single-cycle count enable on the system clock. A chain of four small prescalers divides these enables by 10, 10, 10 and 3, which is 3000 in total, and produces a one-pulse-per-minute strobe.

That strobe steps four digit counters: minutes units, minutes tens, hours units and hours tens. Each counter is a one-hot ring, not a binary count. A carry leaves a ring in the same cycle that the ring wraps to position 0. The seven-segment pattern of each digit is the OR of fixed glyph masks selected by the active ring bit, so no binary decoder sits in the path. Two push inputs set the time by hand. One advances the minutes field and the other advances the hours field, and neither carries into the other field.

Top module: `mains_clock`

## Requirements
- R1: While reset is high, and in the cycle after it, every digit shows 0 (segment bus 7'h3F) and the minute strobe is low. Reset also empties all prescaler stages.
- R2: The segment buses are active high. Bit 0 is segment a, through to bit 6, which is segment g. The patterns are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R3: Every rising edge of the mains tick is counted exactly once. The minute strobe rises exactly once per 3000 counted edges. It is high for one system cycle, in the third cycle after the input rise that completes the count.
- R4: Each minute strobe advances the displayed time by one minute. The display changes on the edge that ends the strobe cycle.
- R5: Minutes units wrap from 9 to 0 and step the tens digit. Minutes tens wrap from 5 to 0 and step the hours. Each carry takes effect in the same cycle as its wrap.
- R6: Hours follow 24-hour form. Hours units wrap from 9 to 0 while the hours tens digit is below 2, and from 3 to 0 while it is 2, so 23:59 is followed by 00:00.
- R7: A rising edge on set_min advances the minutes by one. A wrap from 59 to 00 caused this way leaves the hours unchanged.
- R8: A rising edge on set_hour advances the hours by one, wrapping from 23 to 00, and leaves the minutes unchanged.
- R9: Every ring holds exactly one active bit. A ring found in any other state is forced to position 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mains_tick | input | 1 | Conditioned 50 Hz mains square wave, asynchronous |
| set_min | input | 1 | Minute-advance button, asynchronous level |
| set_hour | input | 1 | Hour-advance button, asynchronous level |
| seg_ht | output | 7 | Segments of the hours tens digit |
| seg_hu | output | 7 | Segments of the hours units digit |
| seg_mt | output | 7 | Segments of the minutes tens digit |
| seg_mu | output | 7 | Segments of the minutes units digit |
| ppm | output | 1 | One-pulse-per-minute strobe |

## Verification
A rising edge on mains_tick or on either button is captured by two synchronizer stages and then appears as a one-cycle enable. The minute strobe is high in the third cycle after the input rises, and the digits change at the clock edge that ends that cycle. The bench counts strobes on falling clock edges, so each strobe counts once and nothing is read while the registers update. It compares the display only after every button row and every burst of mains cycles has been followed by six idle cycles, which is well past the three-edge latency. The mains tick stays high for two cycles and low for two, so no edge can be merged with the next or missed.

// File: rtl/mains_clock_pkg.sv
package mains_clock_pkg;

    localparam int NUM_PRE    = 4;
    localparam int SEG_W      = 7;
    localparam int GLYPH_ROWS = 10;

    localparam int MU_POS = 10;
    localparam int MT_POS = 6;
    localparam int HU_POS = 10;
    localparam int HT_POS = 3;

    localparam int HU_LAST_LOW  = 9;
    localparam int HU_LAST_HIGH = 3;
    localparam int HT_HIGH      = 2;

    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        seg_t ht;
        seg_t hu;
        seg_t mt;
        seg_t mu;
    } disp_t;

    function automatic int pre_div(input int idx);
        case (idx)
            0: return 10;
            1: return 10;
            2: return 10;
            default: return 3;
        endcase
    endfunction

    function automatic seg_t glyph(input int pos);
        case (pos)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            5: return 7'h6D;
            6: return 7'h7D;
            7: return 7'h07;
            8: return 7'h7F;
            default: return 7'h6F;
        endcase
    endfunction

    function automatic seg_t ring_to_seg(input logic [GLYPH_ROWS-1:0] ring);
        seg_t acc;
        acc = '0;
        for (int p = 0; p < GLYPH_ROWS; p++) begin
            acc = acc | ({SEG_W{ring[p]}} & glyph(p));
        end
        return acc;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/prescale_stage.sv
module prescale_stage #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic carry_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign carry_o = en_i & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ring_digit.sv
module ring_digit #(
    parameter int N = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv_i,
    input  logic [$clog2(N)-1:0] last_i,
    output logic [N-1:0]         ring_o,
    output logic                 wrap_o
);
    localparam logic [N-1:0] HOME = N'(1);

    logic [N-1:0] ring_q;
    logic         legal;
    logic         at_last;

    assign legal   = (ring_q != '0) && ((ring_q & (ring_q - 1'b1)) == '0);
    assign at_last = ring_q[last_i];
    assign wrap_o  = adv_i & legal & at_last;
    assign ring_o  = ring_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= HOME;
        end else if (adv_i) begin
            if (!legal || at_last) begin
                ring_q <= HOME;
            end else begin
                ring_q <= {ring_q[N-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/mains_clock.sv
module mains_clock
    import mains_clock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mains_tick,
    input  logic       set_min,
    input  logic       set_hour,
    output logic [6:0] seg_ht,
    output logic [6:0] seg_hu,
    output logic [6:0] seg_mt,
    output logic [6:0] seg_mu,
    output logic       ppm
);
    localparam int MUW = $clog2(MU_POS);
    localparam int MTW = $clog2(MT_POS);
    localparam int HUW = $clog2(HU_POS);
    localparam int HTW = $clog2(HT_POS);

    logic tick_pulse;
    logic min_press;
    logic hour_press;

    edge_sync u_tick_sync (.clk(clk), .rst(rst), .async_i(mains_tick), .rise_o(tick_pulse));
    edge_sync u_min_sync  (.clk(clk), .rst(rst), .async_i(set_min),    .rise_o(min_press));
    edge_sync u_hour_sync (.clk(clk), .rst(rst), .async_i(set_hour),   .rise_o(hour_press));

    logic [NUM_PRE:0] pre_en;
    assign pre_en[0] = tick_pulse;

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        prescale_stage #(.DIV(pre_div(g))) u_stage (
            .clk    (clk),
            .rst    (rst),
            .en_i   (pre_en[g]),
            .carry_o(pre_en[g+1])
        );
    end

    assign ppm = pre_en[NUM_PRE];

    logic [MU_POS-1:0] mu_ring;
    logic [MT_POS-1:0] mt_ring;
    logic [HU_POS-1:0] hu_ring;
    logic [HT_POS-1:0] ht_ring;
    logic mu_wrap, mt_wrap, hu_wrap, ht_wrap;
    logic clock_minute;
    logic hu_adv;
    logic [HUW-1:0] hu_last;

    assign clock_minute = ppm & ~min_press;
    assign hu_adv       = (mt_wrap & clock_minute) | hour_press;
    assign hu_last      = ht_ring[HT_HIGH] ? HUW'(HU_LAST_HIGH) : HUW'(HU_LAST_LOW);

    ring_digit #(.N(MU_POS)) u_mu (
        .clk(clk), .rst(rst), .adv_i(ppm | min_press),
        .last_i(MUW'(MU_POS - 1)), .ring_o(mu_ring), .wrap_o(mu_wrap)
    );

    ring_digit #(.N(MT_POS)) u_mt (
        .clk(clk), .rst(rst), .adv_i(mu_wrap),
        .last_i(MTW'(MT_POS - 1)), .ring_o(mt_ring), .wrap_o(mt_wrap)
    );

    ring_digit #(.N(HU_POS)) u_hu (
        .clk(clk), .rst(rst), .adv_i(hu_adv),
        .last_i(hu_last), .ring_o(hu_ring), .wrap_o(hu_wrap)
    );

    ring_digit #(.N(HT_POS)) u_ht (
        .clk(clk), .rst(rst), .adv_i(hu_wrap),
        .last_i(HTW'(HT_POS - 1)), .ring_o(ht_ring), .wrap_o(ht_wrap)
    );

    disp_t disp;

    always_comb begin
        disp.mu = ring_to_seg(GLYPH_ROWS'(mu_ring));
        disp.mt = ring_to_seg(GLYPH_ROWS'(mt_ring));
        disp.hu = ring_to_seg(GLYPH_ROWS'(hu_ring));
        disp.ht = ring_to_seg(GLYPH_ROWS'(ht_ring));
    end

    assign seg_ht = disp.ht;
    assign seg_hu = disp.hu;
    assign seg_mt = disp.mt;
    assign seg_mu = disp.mu;

    logic unused_wrap;
    assign unused_wrap = ht_wrap;
endmodule

// File: rtl/mains_clock_chk.sv
module mains_clock_chk (
    input logic       clk,
    input logic       rst,
    input logic       ppm,
    input logic       tick_pulse,
    input logic       min_press,
    input logic [9:0] mu_ring,
    input logic [5:0] mt_ring,
    input logic [9:0] hu_ring,
    input logic [2:0] ht_ring,
    input logic [6:0] seg_ht,
    input logic [6:0] seg_hu,
    input logic [6:0] seg_mt,
    input logic [6:0] seg_mu
);
    // R1
    reset_display_chk: assert property (@(posedge clk)
        rst |=> (seg_ht == 7'h3F && seg_hu == 7'h3F && seg_mt == 7'h3F && seg_mu == 7'h3F && !ppm));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        ppm |=> !ppm);

    // R3
    strobe_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ppm |-> tick_pulse);

    // R4
    minute_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ppm && !min_press) |=> !$stable(mu_ring));

    // R6
    hour_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ht_ring[2] |-> (hu_ring[9:4] == 6'b0));

    // R9
    ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(mu_ring) == 1) && ($countones(mt_ring) == 1) &&
        ($countones(hu_ring) == 1) && ($countones(ht_ring) == 1));
endmodule

bind mains_clock mains_clock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ppm       (ppm),
    .tick_pulse(tick_pulse),
    .min_press (min_press),
    .mu_ring   (mu_ring),
    .mt_ring   (mt_ring),
    .hu_ring   (hu_ring),
    .ht_ring   (ht_ring),
    .seg_ht    (seg_ht),
    .seg_hu    (seg_hu),
    .seg_mt    (seg_mt),
    .seg_mu    (seg_mu)
);

// File: tb/mains_clock_bench.sv
module mains_clock_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mains_tick = 1'b0;
    logic set_min = 1'b0;
    logic set_hour = 1'b0;
    logic [6:0] seg_ht, seg_hu, seg_mt, seg_mu;
    logic ppm;

    int checks = 0;
    int fails = 0;
    int ppm_count = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mains_clock u_mains_clock (
        .clk(clk), .rst(rst), .mains_tick(mains_tick),
        .set_min(set_min), .set_hour(set_hour),
        .seg_ht(seg_ht), .seg_hu(seg_hu), .seg_mt(seg_mt), .seg_mu(seg_mu),
        .ppm(ppm)
    );

    always @(negedge clk) if (!rst && ppm) ppm_count++;

    // R2 glyph table as stated in the requirement
    function automatic logic [6:0] seg_of(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [27:0] disp_of(input int hh, input int mm);
        return {seg_of(hh / 10), seg_of(hh % 10), seg_of(mm / 10), seg_of(mm % 10)};
    endfunction

    task automatic check_disp(input string req, input int hh, input int mm);
        logic [27:0] act, exp;
        act = {seg_ht, seg_hu, seg_mt, seg_mu};
        exp = disp_of(hh, mm);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s display actual=%h expected=%h (%02d:%02d)", req, act, exp, hh, mm);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic mains_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) mains_tick = 1'b1;
            @(negedge clk);
            @(negedge clk) mains_tick = 1'b0;
            @(negedge clk);
        end
        idle(6);
    endtask

    task automatic press(input bit hour, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hour) set_hour = 1'b1; else set_min = 1'b1;
            idle(2);
            set_hour = 1'b0;
            set_min = 1'b0;
            idle(3);
        end
        idle(6);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(1);
    endtask

    // {hour_button, presses, expected hours, expected minutes}
    localparam int NV = 10;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {1'b0, 8'd8,  8'd0,  8'd9},
        {1'b0, 8'd1,  8'd0,  8'd10},
        {1'b0, 8'd49, 8'd0,  8'd59},
        {1'b0, 8'd1,  8'd0,  8'd0},
        {1'b1, 8'd9,  8'd9,  8'd0},
        {1'b1, 8'd1,  8'd10, 8'd0},
        {1'b1, 8'd13, 8'd23, 8'd0},
        {1'b1, 8'd1,  8'd0,  8'd0},
        {1'b1, 8'd23, 8'd23, 8'd0},
        {1'b0, 8'd59, 8'd23, 8'd59}
    };

    initial begin
        idle(4);
        // R1 reset state
        check_disp("R1", 0, 0);
        check_int("R1 ppm", int'(ppm), 0);
        rst = 1'b0;
        idle(2);
        check_disp("R1", 0, 0);

        // R3 strobe only on the 3000th edge, R4 minute step
        mains_cycles(2999);
        check_int("R3 no strobe before 3000", ppm_count, 0);
        check_disp("R4 before minute", 0, 0);
        mains_cycles(1);
        check_int("R3 one strobe at 3000", ppm_count, 1);
        check_disp("R4 one minute", 0, 1);

        // R5 R7 R8 R6 through the vector table
        for (int v = 0; v < NV; v++) begin
            press(VEC[v][24], int'(VEC[v][23:16]));
            if (VEC[v][24]) check_disp("R8/R6 set hour", int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            else            check_disp("R7/R5 set minute", int'(VEC[v][15:8]), int'(VEC[v][7:0]));
        end

        // R6 R5 day wrap from the minute strobe
        mains_cycles(3000);
        check_int("R3 second strobe", ppm_count, 2);
        check_disp("R6 23:59 to 00:00", 0, 0);

        // R5 R6 carry 19:59 -> 20:00
        press(1'b1, 19);
        press(1'b0, 59);
        check_disp("R9 valid digits", 19, 59);
        mains_cycles(3000);
        check_disp("R5 19:59 to 20:00", 20, 0);

        // R1 reset clears prescaler mid-count
        mains_cycles(1500);
        do_reset();
        check_disp("R1 after reset", 0, 0);
        ppm_count = 0;
        mains_cycles(2999);
        check_int("R1 prescaler cleared", ppm_count, 0);
        mains_cycles(1);
        check_int("R3 strobe after reset", ppm_count, 1);
        check_disp("R4 after reset", 0, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule